// File: doc/BRIEF.md
# Light-Load Sleep Sequencer

This block decides when a switching regulator stops fixed-frequency switching and goes to sleep to save power at light load, and when it comes back. At each converter clock-cycle strobe it looks at the zero-current comparator output. The comparator fires when the rectifier current is about to reverse. After a run of consecutive cycles that each carry such a pulse, the block puts the converter to sleep. Sleep stops switching and asks the analog front end to disconnect the compensation node from the error amplifier so that the node holds its voltage.

The block leaves sleep when the feedback-low comparator reports that the output has dropped by about two percent. It then keeps switching off for a fixed settling delay, counted in system clocks, and re-enables it afterwards. Sleep is only allowed after soft-start has finished and while automatic light-load operation is selected. A shutdown request returns the block to its running state at once and clears the count, and so does a soft-start restart.

Top module: `lightload_sleep_ctl`

## Requirements
- R1: After reset, `sleep_o` and `hold_o` are 0, `sw_en_o` is 1, and `zc_cnt_o` is 0.
- R2: While running, with sleep allowed, a strobe cycle (`cyc_tick`=1) with `zc_pulse`=1 increments `zc_cnt_o` by one. A strobe cycle with `zc_pulse`=0 clears it. Cycles without a strobe leave it unchanged, so only consecutive pulsed strobes count.
- R3: A pulsed strobe that arrives while `zc_cnt_o` equals THRESH-1 (6 by default, so the seventh consecutive pulse) puts the block to sleep on the next cycle. In sleep `sleep_o` is 1, `sw_en_o` is 0 and `zc_cnt_o` is 0.
- R4: While `pfm_dis`=1, `zc_cnt_o` stays 0 and sleep is never entered. If `pfm_dis` rises during sleep, the wake delay starts, the same as for a feedback-low event.
- R5: While `ss_done`=0, the block is in the running state on the next cycle (`sw_en_o`=1, `sleep_o`=0, `hold_o`=0) with `zc_cnt_o`=0, whatever state it was in before.
- R6: `hold_o` is 1 in sleep and for the whole wake delay, and 0 while switching is enabled.
- R7: `fb_low`=1 during sleep ends sleep on the next cycle (`sleep_o`=0, `hold_o`=1, `sw_en_o`=0). `sw_en_o` returns to 1 exactly WAKE_CYC clocks after that cycle.
- R8: `sd_req`=1 returns the block to the running state on the next cycle with `zc_cnt_o`=0. This takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock strobe per converter switching cycle |
| zc_pulse | input | 1 | Zero-current comparator output for the current strobe |
| fb_low | input | 1 | Feedback has fallen below the wake threshold |
| pfm_dis | input | 1 | 1 keeps fixed-frequency switching and forbids sleep |
| ss_done | input | 1 | Soft-start has completed |
| sd_req | input | 1 | Shutdown request |
| sleep_o | output | 1 | Converter is asleep |
| hold_o | output | 1 | Disconnect the compensation node and hold it at high impedance |
| sw_en_o | output | 1 | Switching permitted |
| zc_cnt_o | output | CNT_W | Current run of consecutive pulsed strobes |

## Verification
Every result comes from a state register, so each output reflects the inputs sampled at one rising edge and is due one clock after that edge. The wake delay is the only exception: `sw_en_o` rises WAKE_CYC clocks after the state leaves sleep. The bench changes inputs on falling edges and compares the outputs with a behavioural model on every falling edge. The model is updated at the same rising edges as the design, so each comparison falls half a cycle after the result is due. The directed checks count whole clocks between the stimulus and the sample, including the exact edge on which the wake delay ends and the edge one clock before it.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } sleep_st_t;

  // next value of a consecutive-pulse run counter
  function automatic logic [7:0] streak_next(input logic [7:0] cur,
                                             input logic tick,
                                             input logic pulse,
                                             input logic clr);
    logic [7:0] r;
    if (clr)              r = 8'd0;
    else if (!tick)       r = cur;
    else if (pulse)       r = cur + 8'd1;
    else                  r = 8'd0;
    return r;
  endfunction

  // next value of a down-counting delay timer
  function automatic logic [31:0] delay_next(input logic [31:0] cur,
                                             input logic load,
                                             input logic [31:0] init);
    logic [31:0] r;
    if (load)            r = init;
    else if (cur != 0)   r = cur - 32'd1;
    else                 r = cur;
    return r;
  endfunction

endpackage

// File: rtl/zc_streak.sv
module zc_streak #(
  parameter int CNT_W  = 3,
  parameter int THRESH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             pulse,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  import sleep_ctl_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       nxt_w;

  assign hit   = !clr && tick && pulse && (cnt_q == LAST);
  assign nxt_w = streak_next(8'(cnt_q), tick, pulse, clr || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_w[CNT_W-1:0];
  end

  assign cnt = cnt_q;

  // R2
  streak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pulse) |=> (cnt == '0));

  // R2
  streak_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && pulse && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  streak_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int WAKE_CYC = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  import sleep_ctl_pkg::*;

  localparam int TW = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
  localparam logic [31:0] INIT = 32'(WAKE_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [31:0]   nxt_w;

  assign nxt_w = delay_next(32'(cnt_q), load, INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_w[TW-1:0];
  end

  assign done = (cnt_q == '0);

  // R7
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (32'(cnt_q) == INIT));

  // R7
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lightload_sleep_ctl.sv
module lightload_sleep_ctl #(
  parameter int CNT_W    = 3,
  parameter int THRESH   = 7,
  parameter int WAKE_CYC = 3125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  logic             zc_pulse,
  input  logic             fb_low,
  input  logic             pfm_dis,
  input  logic             ss_done,
  input  logic             sd_req,
  output logic             sleep_o,
  output logic             hold_o,
  output logic             sw_en_o,
  output logic [CNT_W-1:0] zc_cnt_o
);
  import sleep_ctl_pkg::*;

  sleep_st_t st_q, st_d;

  logic abort_w;
  logic streak_clr_w;
  logic streak_hit_w;
  logic enter_sleep_w;
  logic wake_req_w;
  logic wake_load_w;
  logic wake_done_w;
  logic [CNT_W-1:0] cnt_w;

  assign abort_w       = sd_req || !ss_done;
  assign streak_clr_w  = abort_w || pfm_dis || (st_q != ST_RUN);
  assign enter_sleep_w = (st_q == ST_RUN) && streak_hit_w;
  assign wake_req_w    = (st_q == ST_SLEEP) && (fb_low || pfm_dis);
  assign wake_load_w   = !abort_w && wake_req_w;

  zc_streak #(.CNT_W(CNT_W), .THRESH(THRESH)) u_streak (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (streak_clr_w),
    .tick  (cyc_tick),
    .pulse (zc_pulse),
    .cnt   (cnt_w),
    .hit   (streak_hit_w)
  );

  wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wake_load_w),
    .done  (wake_done_w)
  );

  always_comb begin
    st_d = st_q;
    if (abort_w) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN:   if (enter_sleep_w) st_d = ST_SLEEP;
        ST_SLEEP: if (wake_req_w)    st_d = ST_WAKE;
        ST_WAKE:  if (wake_done_w)   st_d = ST_RUN;
        default:                     st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign sleep_o  = (st_q == ST_SLEEP);
  assign hold_o   = (st_q == ST_SLEEP) || (st_q == ST_WAKE);
  assign sw_en_o  = (st_q == ST_RUN);
  assign zc_cnt_o = cnt_w;

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en_o && cyc_tick && zc_pulse && !pfm_dis && ss_done && !sd_req &&
     zc_cnt_o == CNT_W'(THRESH - 1)) |=> (sleep_o && !sw_en_o && zc_cnt_o == '0));

  // R4
  no_sleep_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfm_dis && !sleep_o) |=> (!sleep_o && zc_cnt_o == '0));

  // R5
  ss_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> (sw_en_o && !hold_o && zc_cnt_o == '0));

  // R8
  sd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_req |=> (sw_en_o && !sleep_o && zc_cnt_o == '0));

  // R7
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && fb_low && ss_done && !sd_req) |=> (hold_o && !sleep_o && !sw_en_o));

  // R6
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_en_o, hold_o}) && (sleep_o -> hold_o));

endmodule

// File: tb/sim_lightload_sleep_ctl.sv
`timescale 1ns/1ps
module sim_lightload_sleep_ctl;
  localparam int CNT_W = 3;
  localparam int THR   = 7;
  localparam int WAKE  = 3125;

  logic clk = 0, rst_n = 0;
  logic cyc_tick = 0, zc_pulse = 0, fb_low = 0, pfm_dis = 0, ss_done = 0, sd_req = 0;
  logic sleep_o, hold_o, sw_en_o;
  logic [CNT_W-1:0] zc_cnt_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lightload_sleep_ctl #(.CNT_W(CNT_W), .THRESH(THR), .WAKE_CYC(WAKE)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .zc_pulse(zc_pulse),
    .fb_low(fb_low), .pfm_dis(pfm_dis), .ss_done(ss_done), .sd_req(sd_req),
    .sleep_o(sleep_o), .hold_o(hold_o), .sw_en_o(sw_en_o), .zc_cnt_o(zc_cnt_o));

  // behavioural reference: 0 running, 1 asleep, 2 settling
  int m_mode = 0, m_run = 0, m_left = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_left = 0;
    end else if (sd_req || !ss_done) begin
      m_mode = 0; m_run = 0;
    end else if (m_mode == 0) begin
      if (pfm_dis) m_run = 0;
      else if (cyc_tick) begin
        if (!zc_pulse) m_run = 0;
        else if (m_run + 1 == THR) begin m_mode = 1; m_run = 0; end
        else m_run = m_run + 1;
      end
    end else if (m_mode == 1) begin
      if (fb_low || pfm_dis) begin m_mode = 2; m_left = WAKE - 1; end
    end else begin
      if (m_left == 0) m_mode = 0;
      else m_left = m_left - 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 sleep_o model", int'(sleep_o), int'(m_mode == 1));
    chk("R6 hold_o model", int'(hold_o), int'(m_mode != 0));
    chk("R7 sw_en_o model", int'(sw_en_o), int'(m_mode == 0));
    chk("R2 zc_cnt_o model", int'(zc_cnt_o), m_run);
  end

  // apply inputs for one rising edge, return on the following falling edge
  task automatic step(input bit t, input bit z, input bit f);
    cyc_tick = t; zc_pulse = z; fb_low = f;
    @(negedge clk);
    cyc_tick = 0; zc_pulse = 0; fb_low = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin step(1, 1, 0); step(0, 0, 0); end
  endtask

  task automatic full_wake();
    step(0, 0, 1);
    for (int i = 0; i < WAKE; i++) step(0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset sleep", int'(sleep_o), 0);
    chk("R1 reset hold", int'(hold_o), 0);
    chk("R1 reset sw_en", int'(sw_en_o), 1);
    chk("R1 reset cnt", int'(zc_cnt_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R5: before soft-start completes pulses do not count
    pulses(10);
    chk("R5 no count before ss", int'(zc_cnt_o), 0);
    chk("R5 no sleep before ss", int'(sleep_o), 0);
    ss_done = 1;
    @(negedge clk);

    // R2 counting, holding between strobes, clearing on empty strobe
    pulses(3);
    chk("R2 count three", int'(zc_cnt_o), 3);
    step(0, 1, 0);
    chk("R2 no strobe holds", int'(zc_cnt_o), 3);
    step(1, 0, 0);
    chk("R2 empty strobe clears", int'(zc_cnt_o), 0);

    // R3 seventh consecutive pulse enters sleep
    pulses(6);
    chk("R3 six counted", int'(zc_cnt_o), 6);
    chk("R3 still running", int'(sw_en_o), 1);
    step(1, 1, 0);
    chk("R3 asleep", int'(sleep_o), 1);
    chk("R3 switching off", int'(sw_en_o), 0);
    chk("R6 hold in sleep", int'(hold_o), 1);
    pulses(2);
    chk("R3 stays asleep", int'(sleep_o), 1);

    // R7 wake timing
    step(0, 0, 1);
    chk("R7 sleep cleared", int'(sleep_o), 0);
    chk("R6 hold during delay", int'(hold_o), 1);
    for (int i = 0; i < WAKE - 1; i++) step(0, 0, 0);
    chk("R7 one clock before end", int'(sw_en_o), 0);
    step(0, 0, 0);
    chk("R7 switching resumed", int'(sw_en_o), 1);
    chk("R6 hold released", int'(hold_o), 0);

    // R4 disable input blocks sleep
    pfm_dis = 1;
    pulses(12);
    chk("R4 no sleep when disabled", int'(sleep_o), 0);
    chk("R4 count held zero", int'(zc_cnt_o), 0);
    pfm_dis = 0;
    pulses(7);
    chk("R4 sleeps once allowed", int'(sleep_o), 1);
    pfm_dis = 1;
    step(0, 0, 0);
    chk("R4 disable wakes", int'(hold_o), 1);
    chk("R4 disable wakes sleep_o", int'(sleep_o), 0);
    pfm_dis = 0;
    for (int i = 0; i < WAKE; i++) step(0, 0, 0);
    chk("R4 resumed", int'(sw_en_o), 1);

    // R8 shutdown from sleep and from counting
    pulses(7);
    chk("R8 asleep before sd", int'(sleep_o), 1);
    sd_req = 1;
    step(0, 0, 0);
    chk("R8 sd running", int'(sw_en_o), 1);
    sd_req = 0;
    pulses(4);
    sd_req = 1;
    step(0, 0, 0);
    chk("R8 sd clears count", int'(zc_cnt_o), 0);
    sd_req = 0;

    // R5 soft-start restart during wake delay
    pulses(7);
    step(0, 0, 1);
    ss_done = 0;
    step(0, 0, 0);
    chk("R5 restart ends delay", int'(sw_en_o), 1);
    ss_done = 1;
    @(negedge clk);

    // mixed stimulus compared against the model each clock
    for (int i = 0; i < 40000; i++) begin
      bit t, z, f;
      t = ($urandom_range(0, 2) == 0);
      z = ($urandom_range(0, 15) != 0);
      f = ($urandom_range(0, 299) == 0);
      pfm_dis = ($urandom_range(0, 999) == 0) ? ~pfm_dis : pfm_dis;
      sd_req  = ($urandom_range(0, 1999) == 0);
      ss_done = ($urandom_range(0, 2999) == 0) ? 1'b0 : 1'b1;
      step(t, z, f);
    end
    pfm_dis = 0; sd_req = 0; ss_done = 1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule